// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block holds a small bank of wide event counters for profiling a processor core. Each counter watches one of a set of single-cycle event strobes and steps by one in every cycle in which its chosen strobe is high, the bank is globally running and the current privilege mode passes the counter's mode filter. Condition number 0 never fires, so writing 0 as a counter's condition is the way to stop that one counter.

Software reaches the bank through a compact register window. A counter-select register picks one counter, and the configuration, count-load and snapshot registers then act on that counter only. A counter is preset with two 32-bit writes, one for its lower word and one for its upper part. Reading a running counter safely is done by setting a snapshot bit in the control register. That bit copies the whole counter into a pair of snapshot registers in one cycle, so the two halves always belong together. Two read-only build registers describe how many counters there are, how wide they are and how many conditions exist. A condition-select register exposes an 8-character ASCII name for each condition.

Top module: `pct_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, the control register, the counter select, every configuration and the snapshot registers read 0.
- R2: The counter select register (address 1, bits IDX_W-1:0) chooses the counter that the configuration (address 2), count-low (address 3), count-high (address 4) and snapshot accesses act on. Other counters are not touched.
- R3: A counter whose condition field (configuration bits 14:0) is 0 never counts, whatever the strobes show.
- R4: A counter with condition c (1 <= c < NUM_COND) steps by exactly one on every clock edge at which the global enable is set, event strobe c is high and the mode filter passes. It does not step on any other strobe.
- R5: Control bit 0 (address 0) enables all counters together. With it clear, no counter changes. Control bits 31:16 are stored as written and read back unchanged.
- R6: Writing the control register with bit 1 set copies the selected counter's value from before that edge into snapshot-low (address 5, bits 31:0) and snapshot-high (address 6, upper bits right-aligned). The snapshot then holds until the next such write, and control bit 1 always reads 0.
- R7: A write to count-low loads bits 31:0 of the selected counter. A write to count-high loads the upper CNT_W-32 bits from the low bits of the write data. Both are read back live at the same addresses, and a carry out of the low word reaches the upper part.
- R8: Configuration bit 16 lets the counter count only while kernel_mode is 1. Bit 17 lets it count only while kernel_mode is 0. With neither bit set, it counts in both modes.
- R9: The counter build register (address 7) reads bit 0 = 1 (present), bits 15:8 = NUM_CNT, bits 17:16 = CNT_EXT (width is 32+16*CNT_EXT) and bit 20 = 0 (no overflow interrupt).
- R10: The condition build register (address 8) reads bit 0 = 1 and bits 15:8 = NUM_COND. With a condition index written to address 9, name word 0 (address 10) reads "evt_" and name word 1 (address 11) reads the index as four upper-case hex digits, most significant first. In both words the first character sits in the least significant byte.
- R11: A condition number at or above NUM_COND never counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register write address |
| bus_wdata | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational from current state |
| event_in | input | NUM_COND | Event condition strobes, bit c is condition c |
| kernel_mode | input | 1 | 1 while the core runs in kernel mode |

## Verification
The checker assumes that at most one register write happens per cycle. When bus_wr is low it assumes the counter select cannot move, so the selected counter may change by at most one per cycle and must hold while its condition is 0 or the bank is disabled. The stimulus writes only through a task that asserts bus_wr for a single edge. Strobes change only between edges and are held for an exact number of edges. Every read is taken while all strobes are low, so the expected counts depend only on the edge count of each pulse.

// File: rtl/pct_pkg.sv
// Shared register addresses, configuration layout and helpers for the
// event counter bank. Assumes a 4-bit register address space.
package pct_pkg;

    typedef enum logic [3:0] {
        RA_CTRL       = 4'd0,
        RA_CNT_IDX    = 4'd1,
        RA_CNT_CFG    = 4'd2,
        RA_CNT_LO     = 4'd3,
        RA_CNT_HI     = 4'd4,
        RA_SNAP_LO    = 4'd5,
        RA_SNAP_HI    = 4'd6,
        RA_BUILD      = 4'd7,
        RA_COND_BUILD = 4'd8,
        RA_COND_IDX   = 4'd9,
        RA_NAME0      = 4'd10,
        RA_NAME1      = 4'd11
    } reg_addr_e;

    // Per-counter configuration: condition number plus two mode filters.
    typedef struct packed {
        logic        user_only;
        logic        kern_only;
        logic [14:0] cond;
    } cnt_cfg_t;

    // ASCII upper-case hex digit for one nibble.
    function automatic logic [7:0] hex_char(input logic [3:0] d);
        return (d < 4'd10) ? (8'h30 + 8'(d)) : (8'h37 + 8'(d));
    endfunction

endpackage

// File: rtl/pct_counter.sv
// One event counter: selects its condition strobe, applies the mode
// filter and the global enable, and accepts a full-width load.
// Assumes the load value is already merged by the register file.
module pct_counter
    import pct_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int NUM_COND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cnt_cfg_t            cfg,
    input  logic [NUM_COND-1:0] events,
    input  logic                kernel_mode,
    input  logic                global_en,
    input  logic                ld_en,
    input  logic [CNT_W-1:0]    ld_val,
    output logic [CNT_W-1:0]    value
);
    localparam int CIW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

    logic cond_valid;
    logic strobe;
    logic mode_ok;
    logic inc;

    // Decide whether this cycle is a counting cycle.
    always_comb begin
        cond_valid = (cfg.cond != 15'd0) && (32'(cfg.cond) < NUM_COND);
        strobe     = cond_valid && events[cfg.cond[CIW-1:0]];
        mode_ok    = (!cfg.kern_only && !cfg.user_only)
                   || (cfg.kern_only && kernel_mode)
                   || (cfg.user_only && !kernel_mode);
        inc        = global_en && strobe && mode_ok;
    end

    // Counter register: a load wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (ld_en)
            value <= ld_val;
        else if (inc)
            value <= value + 1'b1;
    end

endmodule

// File: rtl/pct_cond_names.sv
// Produces the two ASCII name words of a condition from its index:
// "evt_" followed by the index as four hex digits, first character in
// the least significant byte. Purely combinational.
module pct_cond_names
    import pct_pkg::*;
#(
    parameter int CIW = 3
) (
    input  logic [CIW-1:0] cond_sel,
    output logic [31:0]    name0,
    output logic [31:0]    name1
);
    logic [15:0] idx16;

    // Build the name characters for the selected condition.
    always_comb begin
        idx16 = 16'(cond_sel);
        name0 = {8'h5F, 8'h74, 8'h76, 8'h65};
        name1 = {hex_char(idx16[3:0]),  hex_char(idx16[7:4]),
                 hex_char(idx16[11:8]), hex_char(idx16[15:12])};
    end

endmodule

// File: rtl/pct_bank.sv
// Indexed event counter bank with register window. Holds the control,
// select, configuration and snapshot registers and a generated array of
// counters. Assumes one register write per cycle and CNT_EXT of 1 or 2.
module pct_bank
    import pct_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int NUM_COND = 8,
    parameter int CNT_EXT  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          rd_addr,
    output logic [31:0]         rd_data,
    input  logic [NUM_COND-1:0] event_in,
    input  logic                kernel_mode
);
    localparam int CNT_W = 32 + 16 * CNT_EXT;
    localparam int HI_W  = CNT_W - 32;
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam int CIW   = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

    logic             ctrl_en_q;
    logic [15:0]      ctrl_hi_q;
    logic [IDX_W-1:0] cnt_idx_q;
    logic [CIW-1:0]   cond_idx_q;
    logic [CNT_W-1:0] snap_q;
    cnt_cfg_t         cfg_q   [NUM_CNT];
    logic [CNT_W-1:0] cnt_val [NUM_CNT];
    logic [CNT_W-1:0] sel_cnt;
    cnt_cfg_t         sel_cfg;
    logic [31:0]      name0, name1;
    logic             wr_ctrl, wr_lo, wr_hi;

    // Decode the write strobes and the selected counter.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
        wr_lo   = bus_wr && (bus_addr == RA_CNT_LO);
        wr_hi   = bus_wr && (bus_addr == RA_CNT_HI);
        sel_cnt = cnt_val[cnt_idx_q];
        sel_cfg = cfg_q[cnt_idx_q];
    end

    // Control, select and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_hi_q  <= '0;
            cnt_idx_q  <= '0;
            cond_idx_q <= '0;
            snap_q     <= '0;
        end else if (bus_wr) begin
            if (wr_ctrl) begin
                ctrl_en_q <= bus_wdata[0];
                ctrl_hi_q <= bus_wdata[31:16];
                if (bus_wdata[1])
                    snap_q <= sel_cnt;
            end
            if (bus_addr == RA_CNT_IDX)
                cnt_idx_q <= bus_wdata[IDX_W-1:0];
            if (bus_addr == RA_COND_IDX)
                cond_idx_q <= bus_wdata[CIW-1:0];
        end
    end

    // One configuration register and one counter per slot.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic             hit;
        logic [CNT_W-1:0] ld_val;

        // Merge a half-word load with the current value.
        always_comb begin
            hit    = (cnt_idx_q == IDX_W'(g));
            ld_val = wr_lo ? {cnt_val[g][CNT_W-1:32], bus_wdata}
                           : {bus_wdata[HI_W-1:0], cnt_val[g][31:0]};
        end

        // Configuration register of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (bus_wr && hit && (bus_addr == RA_CNT_CFG))
                cfg_q[g] <= '{user_only: bus_wdata[17],
                              kern_only: bus_wdata[16],
                              cond:      bus_wdata[14:0]};
        end

        pct_counter #(.CNT_W(CNT_W), .NUM_COND(NUM_COND)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg         (cfg_q[g]),
            .events      (event_in),
            .kernel_mode (kernel_mode),
            .global_en   (ctrl_en_q),
            .ld_en       (hit && (wr_lo || wr_hi)),
            .ld_val      (ld_val),
            .value       (cnt_val[g])
        );
    end

    pct_cond_names #(.CIW(CIW)) u_names (
        .cond_sel (cond_idx_q),
        .name0    (name0),
        .name1    (name1)
    );

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            RA_CTRL:       rd_data = {ctrl_hi_q, 15'd0, ctrl_en_q};
            RA_CNT_IDX:    rd_data = 32'(cnt_idx_q);
            RA_CNT_CFG:    rd_data = {14'd0, sel_cfg.user_only,
                                      sel_cfg.kern_only, 1'b0, sel_cfg.cond};
            RA_CNT_LO:     rd_data = sel_cnt[31:0];
            RA_CNT_HI:     rd_data = 32'(sel_cnt[CNT_W-1:32]);
            RA_SNAP_LO:    rd_data = snap_q[31:0];
            RA_SNAP_HI:    rd_data = 32'(snap_q[CNT_W-1:32]);
            RA_BUILD:      rd_data = 32'd1 | (32'(NUM_CNT) << 8)
                                   | (32'(CNT_EXT) << 16);
            RA_COND_BUILD: rd_data = 32'd1 | (32'(NUM_COND) << 8);
            RA_COND_IDX:   rd_data = 32'(cond_idx_q);
            RA_NAME0:      rd_data = name0;
            RA_NAME1:      rd_data = name1;
            default:       rd_data = 32'd0;
        endcase
    end

endmodule

// File: rtl/pct_bank_checker.sv
// Temporal checks on the selected counter and the snapshot registers.
// Assumes one write per cycle and that the select only moves on a write.
module pct_bank_checker
    import pct_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             ctrl_en,
    input logic [CNT_W-1:0] sel_cnt,
    input logic [CNT_W-1:0] snap,
    input logic [14:0]      sel_cond
);
    logic snap_req;
    assign snap_req = bus_wr && (bus_addr == RA_CTRL) && bus_wdata[1];

    // R3: condition 0 holds the counter.
    a_r3_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cond == 15'd0 && !bus_wr) |=> $stable(sel_cnt));

    // R4: without writes the counter moves by at most one per cycle.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (sel_cnt == $past(sel_cnt)) || (sel_cnt == $past(sel_cnt) + 1'b1));

    // R5: global disable freezes the counter.
    a_r5_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !bus_wr) |=> $stable(sel_cnt));

    // R6: a snapshot request captures the pre-edge counter value.
    a_r6_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap == $past(sel_cnt)));

    // R6: the snapshot holds without a request.
    a_r6_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap));

    // R7: a low-word load lands in the selected counter.
    a_r7_low_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_CNT_LO) |=> (sel_cnt[31:0] == $past(bus_wdata)));

endmodule

bind pct_bank pct_bank_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_en   (ctrl_en_q),
    .sel_cnt   (sel_cnt),
    .snap      (snap_q),
    .sel_cond  (sel_cfg.cond)
);

// File: tb/pct_bank_tb.sv
// Scoreboard bench: the driver queues expected read values, the monitor
// compares them a quarter period after each falling edge.
module pct_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_COND   = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr = 1'b0;
    logic [3:0]          bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [3:0]          rd_addr = '0;
    logic [31:0]         rd_data;
    logic [NUM_COND-1:0] event_in = '0;
    logic                kernel_mode = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [3:0]  adr_q[$];
    bit          done = 1'b0;

    pct_bank #(.NUM_CNT(4), .NUM_COND(NUM_COND), .CNT_EXT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .event_in(event_in), .kernel_mode(kernel_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag); adr_q.push_back(a);
    endtask

    // Strobes high across exactly k rising edges.
    task automatic pulse(input logic [NUM_COND-1:0] m, input int k);
        @(negedge clk);
        event_in = m;
        repeat (k) @(negedge clk);
        event_in = '0;
    endtask

    // Monitor: pop and compare queued reads.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                logic [3:0] a;
                e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s addr %0d: actual %h expected %h", t, a, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 32'h0, "R1 ctrl");
        rd(4'd1, 32'h0, "R1 index");
        rd(4'd2, 32'h0, "R1 cfg");
        rd(4'd3, 32'h0, "R1 count low");
        rd(4'd4, 32'h0, "R1 count high");
        rd(4'd5, 32'h0, "R1 snapshot low");
        // R9 / R10 build and names
        rd(4'd7, 32'h0001_0401, "R9 build");
        rd(4'd8, 32'h0000_0801, "R10 cond build");
        wr(4'd9, 32'd3);
        rd(4'd10, 32'h5F74_7665, "R10 name0");
        rd(4'd11, 32'h3330_3030, "R10 name1 idx3");
        wr(4'd9, 32'd5);
        rd(4'd11, 32'h3530_3030, "R10 name1 idx5");
        // R4 counting
        wr(4'd0, 32'h1);
        wr(4'd2, 32'h2);
        pulse(8'h04, 5);
        rd(4'd3, 32'd5, "R4 cnt0 five strobes");
        pulse(8'h08, 4);
        rd(4'd3, 32'd5, "R4 other strobe ignored");
        // R2 selection
        wr(4'd1, 32'd1);
        wr(4'd2, 32'h3);
        pulse(8'h0C, 7);
        rd(4'd3, 32'd7, "R2 cnt1");
        rd(4'd2, 32'h3, "R2 cfg of cnt1");
        wr(4'd1, 32'd0);
        rd(4'd3, 32'd12, "R2 cnt0 separate");
        rd(4'd2, 32'h2, "R2 cfg of cnt0 untouched");
        // R3 condition zero stops
        wr(4'd1, 32'd1);
        wr(4'd2, 32'h0);
        pulse(8'hFF, 6);
        rd(4'd3, 32'd7, "R3 cnt1 stopped");
        // R11 out-of-range condition
        wr(4'd1, 32'd2);
        wr(4'd2, 32'd9);
        pulse(8'hFF, 4);
        rd(4'd3, 32'd0, "R11 cnt2 never");
        wr(4'd1, 32'd0);
        rd(4'd3, 32'd22, "R4 cnt0 after all-ones");
        // R5 global enable
        wr(4'd0, 32'hABCD_0000);
        pulse(8'hFF, 5);
        rd(4'd3, 32'd22, "R5 disabled holds");
        rd(4'd0, 32'hABCD_0000, "R5 upper bits kept");
        wr(4'd0, 32'hABCD_0001);
        // R8 mode filters
        wr(4'd2, 32'h0001_0002);
        kernel_mode = 1'b0;
        pulse(8'h04, 3);
        rd(4'd3, 32'd22, "R8 kernel-only in user");
        kernel_mode = 1'b1;
        pulse(8'h04, 4);
        rd(4'd3, 32'd26, "R8 kernel-only in kernel");
        wr(4'd2, 32'h0002_0002);
        pulse(8'h04, 2);
        rd(4'd3, 32'd26, "R8 user-only in kernel");
        kernel_mode = 1'b0;
        pulse(8'h04, 5);
        rd(4'd3, 32'd31, "R8 user-only in user");
        rd(4'd2, 32'h0002_0002, "R8 cfg readback");
        wr(4'd2, 32'h2);
        // R7 split load and carry
        wr(4'd1, 32'd3);
        wr(4'd3, 32'hFFFF_FFFE);
        wr(4'd4, 32'hFFFF_0012);
        rd(4'd4, 32'h0000_0012, "R7 high load");
        rd(4'd3, 32'hFFFF_FFFE, "R7 low load");
        wr(4'd2, 32'h2);
        pulse(8'h04, 3);
        rd(4'd4, 32'h0000_0013, "R7 carry into high");
        rd(4'd3, 32'h0000_0001, "R7 low after wrap");
        // R6 snapshot
        wr(4'd0, 32'hABCD_0003);
        pulse(8'h04, 2);
        rd(4'd5, 32'h0000_0001, "R6 snapshot low");
        rd(4'd6, 32'h0000_0013, "R6 snapshot high");
        rd(4'd0, 32'hABCD_0001, "R6 snap bit reads zero");
        rd(4'd3, 32'h0000_0003, "R6 live counter moved on");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule